// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Control Logic

This block models the control side of a 2048 x 8 byte-wide nonvolatile memory whose pins are sampled on a fast system clock. Three active-low pins (chip enable, output enable, write enable) are decoded every cycle into one of four bus modes: read, write strobe, standby and inhibit. In read mode the stored byte at the presented address drives the data bus. In every other mode the bus is released.

A write strobe is the overlap of chip enable low and write enable low while output enable is high. Either pin may form the strobe edge. While the strobe is active, address and data are copied into shadow registers. When the strobe ends, the final copy moves into write latches and a self-timed write cycle of a parameterised number of clocks begins. A busy output stays high for the whole cycle.

A read during the busy time returns a status byte rather than array data. Strobes that are too short are dropped. Strobes during the busy time are dropped. Strobes that arrive while a power-up lockout window after reset is still open are also dropped. The storage array is an ordinary register array.

Top module: `nvm_ctrl_top`

## Requirements
- R1: After reset, with all three control pins high, `busyOut` is 0 and `dataOe` is 0.
- R2: With `chipEnN`=0, `outEnN`=0 and `wrEnN`=1 while idle, `dataOe` is 1 and `dataOut` equals the byte stored at `addrIn`.
- R3: With `chipEnN`=1 (standby), or with `outEnN` and `wrEnN` both at the same level (inhibit), `dataOe` is 0.
- R4: A write strobe is the condition `chipEnN`=0, `wrEnN`=0, `outEnN`=1. It may be formed with either `wrEnN` or `chipEnN` as the last pin to fall and the first to rise. The byte written is the address and data sampled on the strobe's last clock edge.
- R5: Changes on `addrIn` and `dataIn` after the strobe ends have no effect on the byte stored.
- R6: `busyOut` rises on the first clock edge that samples the strobe gone. It stays high for exactly `WRITE_CYC` clock cycles. The new byte is readable once it falls.
- R7: A read while `busyOut` is 1 drives a status byte. Its bit 7 is the complement of bit 7 of the byte being written, and bits 6..0 are 0.
- R8: A strobe sampled active on fewer than `MIN_PULSE` clock edges starts no write and leaves the array unchanged.
- R9: Strobe cycles that occur while `busyOut` is 1 are not counted. A strobe that ends during the busy time starts no write and changes no byte.
- R10: For the first `LOCK_CYC` clock cycles after reset, no strobe is counted, so `busyOut` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| addrIn | input | 11 | Byte address |
| dataIn | input | 8 | Data bus, input side |
| chipEnN | input | 1 | Chip enable, active low |
| outEnN | input | 1 | Output enable, active low |
| wrEnN | input | 1 | Write enable, active low |
| dataOut | output | 8 | Data bus, output side |
| dataOe | output | 1 | Data bus drive enable; 0 means high impedance |
| busyOut | output | 1 | High while a self-timed write is running |

## Verification
The assertions assume that the control pins are synchronous to `clk` and stable across each sampling edge. They also assume that `WRITE_CYC` is at least 1, so that a busy run ends with a countable length. The bench changes every pin only on the falling clock edge. It holds each pin pattern for whole cycles. It uses short cycle and lockout parameters, which keeps every busy window and the lockout window inside a bounded wait.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_INHIBIT = 2'd1,
    MODE_READ    = 2'd2,
    MODE_STROBE  = 2'd3
  } busMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shadowEn;  // copy bus into shadow registers
    logic launch;    // move shadow into write latches
    logic commit;    // write latches into the array
    logic pollMode;  // reads return status byte
    logic driveBus;  // enable the output driver
  } dpCtrl_t;

endpackage

// File: rtl/nvm_mode_decode.sv
module nvm_mode_decode
  import nvm_pkg::*;
(
  input  logic     chipEnN,
  input  logic     outEnN,
  input  logic     wrEnN,
  output busMode_t mode
);

  always_comb begin
    if (chipEnN)                mode = MODE_STANDBY;
    else if (!outEnN && wrEnN)  mode = MODE_READ;
    else if (outEnN && !wrEnN)  mode = MODE_STROBE;
    else                        mode = MODE_INHIBIT;
  end

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int WRITE_CYC = 1000000,
  parameter int LOCK_CYC  = 2000000,
  parameter int MIN_PULSE = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  busMode_t mode,
  output logic     busy,
  output dpCtrl_t  dpCtrl
);

  localparam int WC_W = $clog2(WRITE_CYC + 1);
  localparam int LK_W = $clog2(LOCK_CYC + 1);
  localparam int PL_W = $clog2(MIN_PULSE + 1);
  localparam logic [WC_W-1:0] TIMER_LOAD = WC_W'(WRITE_CYC - 1);
  localparam logic [LK_W-1:0] LOCK_END   = LK_W'(LOCK_CYC);
  localparam logic [PL_W-1:0] PULSE_MIN  = PL_W'(MIN_PULSE);

  logic [WC_W-1:0] timerQ;
  logic [LK_W-1:0] lockCnt;
  logic [PL_W-1:0] pulseCnt;
  logic            busyQ;
  logic            locked;
  logic            idle;
  logic            strobeNow;
  logic            pulseOk;
  logic            launch;
  logic            commit;

  assign strobeNow = (mode == MODE_STROBE);
  assign locked    = (lockCnt != LOCK_END);
  assign idle      = !busyQ && !locked;
  assign pulseOk   = (pulseCnt == PULSE_MIN);
  assign launch    = idle && !strobeNow && pulseOk;
  assign commit    = busyQ && (timerQ == '0);

  // power-up lockout window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lockCnt <= '0;
    else if (locked) lockCnt <= lockCnt + 1'b1;
  end

  // strobe width, counted only on idle cycles, saturating at the minimum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulseCnt <= '0;
    end else if (strobeNow && idle) begin
      if (!pulseOk) pulseCnt <= pulseCnt + 1'b1;
    end else begin
      pulseCnt <= '0;
    end
  end

  // self-timed write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ  <= 1'b0;
      timerQ <= '0;
    end else if (launch) begin
      busyQ  <= 1'b1;
      timerQ <= TIMER_LOAD;
    end else if (busyQ) begin
      if (timerQ == '0) busyQ <= 1'b0;
      else              timerQ <= timerQ - 1'b1;
    end
  end

  assign busy            = busyQ;
  assign dpCtrl.shadowEn = strobeNow && idle;
  assign dpCtrl.launch   = launch;
  assign dpCtrl.commit   = commit;
  assign dpCtrl.pollMode = busyQ;
  assign dpCtrl.driveBus = (mode == MODE_READ);

endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           dpCtrl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [ADDR_W-1:0] latAddr
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] shadowAddr;
  logic [DATA_W-1:0] shadowData;
  logic [ADDR_W-1:0] latAddrQ;
  logic [DATA_W-1:0] latDataQ;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] readByte;
  logic [DATA_W-1:0] statusByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowAddr <= '0;
      shadowData <= '0;
      latAddrQ   <= '0;
      latDataQ   <= '0;
    end else begin
      if (dpCtrl.shadowEn) begin
        shadowAddr <= addrIn;
        shadowData <= dataIn;
      end
      if (dpCtrl.launch) begin
        latAddrQ <= shadowAddr;
        latDataQ <= shadowData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dpCtrl.commit) mem[latAddrQ] <= latDataQ;
  end

  assign readByte   = mem[addrIn];
  assign statusByte = {~latDataQ[DATA_W-1], {(DATA_W-1){1'b0}}};
  assign dataOut    = dpCtrl.pollMode ? statusByte : readByte;
  assign dataOe     = dpCtrl.driveBus;
  assign latAddr    = latAddrQ;

endmodule

// File: rtl/nvm_ctrl_top.sv
module nvm_ctrl_top
  import nvm_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int WRITE_CYC = 1000000,
  parameter int LOCK_CYC  = 2000000,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              wrEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busyOut
);

  busMode_t          mode;
  dpCtrl_t           dpCtrl;
  logic [ADDR_W-1:0] latAddrW;

  nvm_mode_decode u_dec (
    .chipEnN (chipEnN),
    .outEnN  (outEnN),
    .wrEnN   (wrEnN),
    .mode    (mode)
  );

  nvm_ctrl #(
    .WRITE_CYC (WRITE_CYC),
    .LOCK_CYC  (LOCK_CYC),
    .MIN_PULSE (MIN_PULSE)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .busy   (busyOut),
    .dpCtrl (dpCtrl)
  );

  nvm_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .dpCtrl  (dpCtrl),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .latAddr (latAddrW)
  );

endmodule

// File: rtl/nvm_ctrl_checker.sv
module nvm_ctrl_checker #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int WRITE_CYC = 1000000,
  parameter int LOCK_CYC  = 2000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chipEnN,
  input logic              outEnN,
  input logic              wrEnN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              busyOut,
  input logic [ADDR_W-1:0] latAddr
);

  localparam int RUN_W = $clog2(WRITE_CYC + 2);
  localparam int UP_W  = $clog2(LOCK_CYC + 1);

  logic             strobe;
  logic [RUN_W-1:0] busyRun;
  logic [UP_W-1:0]  upCnt;

  assign strobe = !chipEnN && !wrEnN && outEnN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busyRun <= '0;
    else if (busyOut) busyRun <= busyRun + 1'b1;
    else              busyRun <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        upCnt <= '0;
    else if (upCnt != UP_W'(LOCK_CYC)) upCnt <= upCnt + 1'b1;
  end

  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!chipEnN && !outEnN && wrEnN) |-> dataOe);

  p_standby_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chipEnN || (outEnN == wrEnN)) |-> !dataOe);

  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyOut) |-> ($past(strobe, 2) && !$past(strobe)));

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busyOut && $past(busyOut)) |-> $stable(latAddr));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busyOut) |-> (busyRun == RUN_W'(WRITE_CYC)));

  p_busy_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busyOut |-> (busyRun < RUN_W'(WRITE_CYC)));

  p_poll_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busyOut && dataOe) |-> (dataOut[DATA_W-2:0] == '0));

  p_lockout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyOut) |-> (upCnt == UP_W'(LOCK_CYC)));

endmodule

bind nvm_ctrl_top nvm_ctrl_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .WRITE_CYC (WRITE_CYC),
  .LOCK_CYC  (LOCK_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .chipEnN (chipEnN),
  .outEnN  (outEnN),
  .wrEnN   (wrEnN),
  .dataOut (dataOut),
  .dataOe  (dataOe),
  .busyOut (busyOut),
  .latAddr (latAddrW)
);

// File: tb/tb_nvm_ctrl_top.sv
module tb_nvm_ctrl_top;

  localparam int WC = 40;
  localparam int LK = 100;
  localparam int MP = 4;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addrIn = '0;
  logic [7:0]  dataIn = '0;
  logic        chipEnN = 1'b1;
  logic        outEnN = 1'b1;
  logic        wrEnN = 1'b1;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic        busyOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] model [2048];

  always #2.5 clk = ~clk;

  nvm_ctrl_top #(
    .WRITE_CYC (WC),
    .LOCK_CYC  (LK),
    .MIN_PULSE (MP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .dataIn(dataIn),
    .chipEnN(chipEnN), .outEnN(outEnN), .wrEnN(wrEnN),
    .dataOut(dataOut), .dataOe(dataOe), .busyOut(busyOut)
  );

  // {addr, data, ceControlled, pulse cycles, expect write}
  localparam logic [28:0] VEC [NV] = '{
    {11'h005, 8'hA5, 1'b0, 8'd6,  1'b1},
    {11'h7FF, 8'h3C, 1'b1, 8'd5,  1'b1},
    {11'h000, 8'h80, 1'b0, 8'd4,  1'b1},
    {11'h005, 8'h11, 1'b0, 8'd3,  1'b0},
    {11'h7FF, 8'h22, 1'b1, 8'd2,  1'b0},
    {11'h123, 8'h7E, 1'b1, 8'd4,  1'b1},
    {11'h123, 8'hFF, 1'b0, 8'd20, 1'b1},
    {11'h000, 8'h01, 1'b1, 8'd1,  1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pinsIdle();
    chipEnN = 1'b1; outEnN = 1'b1; wrEnN = 1'b1;
  endtask

  // drive a strobe; returns at the first negedge after it ends
  task automatic strobe(input logic [10:0] a, input logic [7:0] d,
                        input bit ceCtl, input int len);
    @(negedge clk);
    addrIn = a; dataIn = d; outEnN = 1'b1;
    if (ceCtl) wrEnN = 1'b0; else chipEnN = 1'b0;
    @(negedge clk);
    if (ceCtl) chipEnN = 1'b0; else wrEnN = 1'b0;
    repeat (len) @(negedge clk);
    if (ceCtl) chipEnN = 1'b1; else wrEnN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readAt(input logic [10:0] a, input logic [7:0] exp, input string req);
    addrIn = a; chipEnN = 1'b0; outEnN = 1'b0; wrEnN = 1'b1;
    #1;
    chk(dataOe === 1'b1 && dataOut === exp, req, int'(dataOut), int'(exp));
  endtask

  task automatic waitDone(output int cnt);
    cnt = 1;
    for (int i = 0; i < WC + 10; i++) begin
      @(negedge clk);
      if (busyOut) cnt++; else break;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int cnt;
    int seen;
    repeat (3) @(negedge clk);
    #1;
    chk(busyOut === 1'b0 && dataOe === 1'b0, "R1 reset", int'({busyOut, dataOe}), 0);
    rst_n = 1'b1;

    // R10: strobe inside the power-up lockout
    strobe(11'h050, 8'h5A, 1'b0, 6);
    pinsIdle();
    seen = 0;
    for (int i = 0; i < WC + 5; i++) begin
      @(negedge clk);
      if (busyOut) seen++;
    end
    chk(seen == 0, "R10 lockout", seen, 0);
    repeat (LK) @(negedge clk);
    #1;
    chk(busyOut === 1'b0 && dataOe === 1'b0, "R1 idle after lockout", int'({busyOut, dataOe}), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [10:0] a;
      logic [7:0]  d;
      bit          ce;
      int          len;
      bit          ew;
      {a, d, ce, len, ew} = {VEC[v][28:18], VEC[v][17:10], VEC[v][9], 32'(VEC[v][8:1]), VEC[v][0]};
      strobe(a, d, ce, len);
      if (ew) begin
        // R6: busy at first sampling of the ended strobe
        chk(busyOut === 1'b1, "R6 busy start", int'(busyOut), 1);
        // R5: scramble bus, R7: poll
        dataIn = ~d;
        readAt(~a, {~d[7], 7'b0}, "R7 poll status");
        waitDone(cnt);
        chk(cnt == WC, "R6 busy length", cnt, WC);
        model[a] = d;
        readAt(a, d, ce ? "R4 ce write R5 latch R2" : "R4 we write R5 latch R2");
      end else begin
        chk(busyOut === 1'b0, "R8 short strobe no busy", int'(busyOut), 0);
        repeat (3) @(negedge clk);
        readAt(a, model[a], "R8 short strobe unchanged");
      end
      @(negedge clk);
      pinsIdle();
    end

    // R9: strobe that ends during busy is ignored
    strobe(11'h200, 8'h96, 1'b0, 5);
    chk(busyOut === 1'b1, "R9 first write busy", int'(busyOut), 1);
    pinsIdle();
    strobe(11'h7FF, 8'hE7, 1'b0, 8);
    pinsIdle();
    waitDone(cnt);
    model[11'h200] = 8'h96;
    repeat (WC + 5) @(negedge clk);
    #1;
    chk(busyOut === 1'b0, "R9 no second busy", int'(busyOut), 0);
    readAt(11'h7FF, model[11'h7FF], "R9 ignored strobe");
    @(negedge clk);
    readAt(11'h200, 8'h96, "R9 first write stored");

    // R3: standby and inhibit
    @(negedge clk);
    chipEnN = 1'b1; outEnN = 1'b0; wrEnN = 1'b1; #1;
    chk(dataOe === 1'b0, "R3 standby", int'(dataOe), 0);
    @(negedge clk);
    chipEnN = 1'b0; outEnN = 1'b1; wrEnN = 1'b1; #1;
    chk(dataOe === 1'b0, "R3 inhibit high", int'(dataOe), 0);
    @(negedge clk);
    chipEnN = 1'b0; outEnN = 1'b0; wrEnN = 1'b0; #1;
    chk(dataOe === 1'b0 && busyOut === 1'b0, "R3 inhibit low", int'({dataOe, busyOut}), 0);
    @(negedge clk);
    pinsIdle();
    repeat (3) @(negedge clk);
    readAt(11'h005, 8'hA5, "R3 inhibit wrote nothing");
    @(negedge clk);
    pinsIdle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule